// File: doc/BRIEF.md
# Self-Correcting Modulo-6 JK Counter

This block is a 3-bit synchronous counter made of three JK flip-flops, named A, B and C from the most significant bit down. With the count enable high it steps through a fixed cycle of six codes on each rising clock edge. The remaining two codes, 011 and 111, are not treated as don't-cares. The fixed JK input equations send each of them back into the cycle on the next enabled clock. A counter that was upset into an unused code therefore recovers on its own.

The control part works out the J and K inputs from the present state. It passes them to the datapath, together with the clear and advance strobes, in one small struct. The datapath holds the three JK cells. A parameter sets the code that the synchronous reset loads. Its default is 000.

Top module: `jkmod6_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, `count` becomes the reset code on that edge whatever `en` is. The reset code is parameter RESET_CODE, default 000.
- R2: With `rst` low and `en` low at a rising edge, `count` keeps its value.
- R3: With `en` high, the valid codes follow the order 000, 001, 010, 100, 101, 110 and then 000 again, one step per edge. `count` is {A,B,C}, with A in bit 2.
- R4: With `en` high, code 011 goes to 100 in one edge.
- R5: With `en` high, code 111 goes to 000 in one edge.
- R6: The next state follows the JK rules: J=K=B for A, J=C and K=1 for B, J=not B and K=1 for C. This gives A+ = A xor B, B+ = (not B) and C, C+ = (not B) and (not C).
- R7: Once `count` holds a valid code, no sequence of enabled or held edges brings it to 011 or 111.
- R8: RESET_CODE may be set to an unused code. Reset then loads that code, and the counter recovers from it as R4 and R5 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to RESET_CODE, active high |
| en | input | 1 | Count enable; low holds the state |
| count | output | 3 | Present state {A,B,C} |

## Verification
The assertions assume that `rst`, `en` and the clock are clean and free of unknown values at every rising edge. They also assume that the state comes only from reset or from earlier enabled edges. An unused code can be present only because RESET_CODE placed it there. The bench changes its inputs only on the falling edge and samples `count` there as well. It reaches 011 and 111 through two more instances whose RESET_CODE is set to those codes. It never forces the state.

// File: rtl/jkmod6_pkg.sv
package jkmod6_pkg;
  localparam int STATE_W = 3;
  localparam int BIT_A = 2;
  localparam int BIT_B = 1;
  localparam int BIT_C = 0;

  typedef struct packed {
    logic j;
    logic k;
  } jk_pair_t;

  typedef struct packed {
    logic clear;
    logic advance;
    jk_pair_t [STATE_W-1:0] jk;
  } dp_strobe_t;
endpackage

// File: rtl/jk_cell.sv
module jk_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic clear,
  input  logic advance,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (clear) q <= RST_VAL;
    else if (advance) begin
      case ({j, k})
        2'b00:   q <= q;
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end

  // R6: toggle on J=K=1, hold on J=K=0
  assert_jk_toggle_R6: assert property (@(posedge clk) disable iff (clear)
    (advance && j && k) |=> (q != $past(q)));
  assert_jk_hold_R6: assert property (@(posedge clk) disable iff (clear)
    (advance && !j && !k) |=> $stable(q));
endmodule

// File: rtl/jkmod6_ctrl.sv
module jkmod6_ctrl import jkmod6_pkg::*; (
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] stateLow,
  output dp_strobe_t strobe
);
  logic bitB, bitC;
  assign bitB = stateLow[1];
  assign bitC = stateLow[0];

  always_comb begin
    strobe.clear      = rst;
    strobe.advance    = en & ~rst;
    strobe.jk[BIT_A].j = bitB;
    strobe.jk[BIT_A].k = bitB;
    strobe.jk[BIT_B].j = bitC;
    strobe.jk[BIT_B].k = 1'b1;
    strobe.jk[BIT_C].j = ~bitB;
    strobe.jk[BIT_C].k = 1'b1;
  end
endmodule

// File: rtl/jkmod6_dp.sv
module jkmod6_dp import jkmod6_pkg::*; #(
  parameter logic [STATE_W-1:0] RESET_CODE = '0
) (
  input  logic               clk,
  input  dp_strobe_t         strobe,
  output logic [STATE_W-1:0] state
);
  for (genvar i = 0; i < STATE_W; i++) begin : g_cell
    jk_cell #(.RST_VAL(RESET_CODE[i])) u_cell (
      .clk    (clk),
      .clear  (strobe.clear),
      .advance(strobe.advance),
      .j      (strobe.jk[i].j),
      .k      (strobe.jk[i].k),
      .q      (state[i])
    );
  end

  // R2: no advance and no clear keeps every bit
  assert_hold_R2: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.advance |=> $stable(state));
endmodule

// File: rtl/jkmod6_counter.sv
module jkmod6_counter import jkmod6_pkg::*; #(
  parameter logic [STATE_W-1:0] RESET_CODE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [STATE_W-1:0] count
);
  dp_strobe_t strobe;

  jkmod6_ctrl u_ctrl (
    .rst     (rst),
    .en      (en),
    .stateLow(count[1:0]),
    .strobe  (strobe)
  );

  jkmod6_dp #(.RESET_CODE(RESET_CODE)) u_dp (
    .clk   (clk),
    .strobe(strobe),
    .state (count)
  );

  logic isUnused;
  assign isUnused = (count == 3'b011) || (count == 3'b111);

  // R1: reset loads the reset code
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (count == RESET_CODE));
  // R4: 011 recovers to 100
  assert_from011_R4: assert property (@(posedge clk) disable iff (rst)
    (en && count == 3'b011) |=> (count == 3'b100));
  // R5: 111 recovers to 000
  assert_from111_R5: assert property (@(posedge clk) disable iff (rst)
    (en && count == 3'b111) |=> (count == 3'b000));
  // R7: valid codes stay valid
  assert_closed_R7: assert property (@(posedge clk) disable iff (rst)
    !isUnused |=> !isUnused);
  // R6: A changes only when B was 1
  assert_a_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !count[BIT_B]) |=> (count[BIT_A] == $past(count[BIT_A])));
endmodule

// File: tb/tb_jkmod6_counter.sv
module tb_jkmod6_counter;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [2:0] count, count011, count111;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jkmod6_counter dut (.clk(clk), .rst(rst), .en(en), .count(count));
  jkmod6_counter #(.RESET_CODE(3'b011)) dut011 (.clk(clk), .rst(rst), .en(en), .count(count011));
  jkmod6_counter #(.RESET_CODE(3'b111)) dut111 (.clk(clk), .rst(rst), .en(en), .count(count111));

  function automatic logic [2:0] ruleNext(input logic [2:0] s);
    return {s[2] ^ s[1], ~s[1] & s[0], ~s[1] & ~s[0]};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic e);
    rst = r; en = e;
    @(negedge clk);
  endtask

  task automatic test_reset();
    step(1'b1, 1'b1);
    check("R1", count, 3'b000);
    check("R8", count011, 3'b011);
    check("R8", count111, 3'b111);
  endtask

  task automatic test_recover();
    step(1'b0, 1'b1);
    check("R4", count011, 3'b100);
    check("R5", count111, 3'b000);
    check("R3", count, 3'b001);
    step(1'b0, 1'b1);
    check("R8", count011, 3'b101);
    check("R8", count111, 3'b001);
  endtask

  task automatic test_cycle();
    logic [2:0] seq [6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};
    step(1'b1, 1'b0);
    check("R1", count, 3'b000);
    for (int n = 1; n <= 13; n++) begin
      logic [2:0] prev;
      prev = count;
      step(1'b0, 1'b1);
      check("R3", count, seq[n % 6]);
      check("R6", count, ruleNext(prev));
      checks++;
      if (count == 3'b011 || count == 3'b111) begin
        errors++;
        $display("FAIL R7 actual %b expected a valid code", count);
      end
    end
  endtask

  task automatic test_hold();
    logic [2:0] held;
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    held = count;
    for (int n = 0; n < 4; n++) begin
      step(1'b0, 1'b0);
      check("R2", count, held);
    end
    step(1'b0, 1'b1);
    check("R2", count, ruleNext(held));
  endtask

  task automatic test_reset_priority();
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    check("R1", count, 3'b000);
    check("R1", count011, 3'b011);
    step(1'b1, 1'b0);
    check("R1", count111, 3'b111);
    step(1'b0, 1'b0);
    check("R2", count111, 3'b111);
    step(1'b0, 1'b1);
    check("R5", count111, 3'b000);
    check("R4", count011, 3'b100);
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_recover();
    test_cycle();
    test_hold();
    test_reset_priority();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule